// File: doc/BRIEF.md
# Six-Voice Wavetable Sound Register File

This block is the processor-side register file of a six-voice wavetable tone generator. A host writes single bytes to ten register addresses. A bank-select register decides which voice the per-voice registers reach. The per-voice registers hold a pitch period, a control byte, a stereo balance, noise settings and a port that streams samples into the voice's 32-entry waveform table. Three registers are shared by all voices: a master balance and two bytes for the low-frequency modulator. All stored values are presented on output ports for the mixer and modulation logic downstream.

The control byte sets what the waveform port does. With the play bit clear, each byte written to the waveform port is stored at the voice's load pointer, and the pointer then steps forward. Writing the control byte with play clear and the direct bit set returns that pointer to entry 0. With the play bit set, the table is frozen and a per-voice period timer steps a play pointer through it. The entry under the play pointer is the voice's current sample output.

Top module: `wt_sound_regs`

## Requirements
- R1: A write to address 0 stores data bits 2..0 as the bank select, visible on `bank_sel` one cycle after the write; reset value is 0. Writes to addresses 10 to 15 change nothing.
- R2: Address 1 stores the master balance and address 5 stores the selected voice's balance, both as a full byte (left level in bits 7..4, right level in bits 3..0).
- R3: The 12-bit period of the selected voice takes its low 8 bits from a write to address 2 and its high 4 bits from bits 3..0 of a write to address 3; bits 7..4 of that write are discarded.
- R4: A write to address 4 sets the selected voice's play flag from bit 7, its direct flag from bit 6 and its 5-bit level from bits 4..0.
- R5: While a voice's play flag is 0, a write to address 6 stores data bits 4..0 in table entry `load_ptr` and then advances `load_ptr` modulo 32. While the play flag is 1, the write leaves the table and `load_ptr` unchanged.
- R6: A write to address 4 with bit 7 = 0 and bit 6 = 1 sets that voice's `load_ptr` to 0. With bit 7 = 0 and bit 6 = 0, the pointer keeps its value.
- R7: Address 7 sets the noise flag (bit 7) and the 5-bit noise rate (bits 4..0) for voices 4 and 5 only. On voices 0 to 3 these outputs stay 0.
- R8: Address 8 stores the 8-bit modulator rate. Address 9 stores the modulator trigger from bit 7 and the 2-bit modulator mode from bits 1..0.
- R9: While a voice plays with period P (P = 4096 when the stored period is 0), its `play_ptr` advances by one modulo 32 exactly once every P clocks. The first step comes P clocks after the play flag becomes visible. `play_ptr` holds while the voice is not playing.
- R10: Each voice's sample output equals its table entry at `play_ptr`. The timer reloads from the period stored before the reloading edge, so a period write lands in the same cycle as a reload shapes only the next interval.
- R11: The bank select accepts values 6 and 7. While it holds either value, writes to addresses 2 to 7 change no voice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| bank_sel | output | 3 | Current voice bank |
| master_bal | output | 8 | Shared balance byte |
| lfo_rate | output | 8 | Modulator rate |
| lfo_trig | output | 1 | Modulator trigger |
| lfo_mode | output | 2 | Modulator mode |
| v_period | output | 72 | Per-voice 12-bit period, voice v at bits 12v+11..12v |
| v_play | output | 6 | Per-voice play flag |
| v_direct | output | 6 | Per-voice direct flag |
| v_level | output | 30 | Per-voice 5-bit level |
| v_bal | output | 48 | Per-voice balance byte |
| v_noise_en | output | 6 | Per-voice noise flag |
| v_noise_rate | output | 30 | Per-voice 5-bit noise rate |
| v_load_ptr | output | 30 | Per-voice table load pointer |
| v_play_ptr | output | 30 | Per-voice play pointer |
| v_sample | output | 30 | Per-voice current sample |

## Verification
Two functions can act in the same cycle: the period timer reloading and a host write to the period register of a playing voice. The bench plays a voice with a short period and rewrites its period at each phase offset of that period in turn, so one write lands on the reload edge. The behavioural model reloads from the value held before the edge. Its play pointer and sample are compared with the design on every clock, so taking the new period too early shows up as a pointer step in the wrong cycle.

// File: rtl/wt_regs_pkg.sv
package wt_regs_pkg;
   // register addresses decoded by the host port
   localparam logic [3:0] RA_BANK     = 4'd0;
   localparam logic [3:0] RA_MBAL     = 4'd1;
   localparam logic [3:0] RA_PER_LO   = 4'd2;
   localparam logic [3:0] RA_PER_HI   = 4'd3;
   localparam logic [3:0] RA_CTRL     = 4'd4;
   localparam logic [3:0] RA_VBAL     = 4'd5;
   localparam logic [3:0] RA_WAVE     = 4'd6;
   localparam logic [3:0] RA_NOISE    = 4'd7;
   localparam logic [3:0] RA_LFO_RATE = 4'd8;
   localparam logic [3:0] RA_LFO_CTRL = 4'd9;

   // control byte fields
   localparam int CTRL_PLAY_BIT = 7;
   localparam int CTRL_DIR_BIT  = 6;
   localparam int LEVEL_W       = 5;
   localparam int NOISE_W       = 5;
endpackage

// File: rtl/wt_play_timer.sv
module wt_play_timer #(
   parameter int PERIOD_W = 12,
   parameter int PTR_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                play,
   input  logic [PERIOD_W-1:0] period,
   output logic [PTR_W-1:0]    play_ptr
);
   localparam int CNT_W = PERIOD_W + 1;

   logic [CNT_W-1:0] span;
   logic [CNT_W-1:0] cnt;

   // a zero period stands for the full range
   always_comb begin
      if (period == '0) span = CNT_W'(1) << PERIOD_W;
      else              span = {1'b0, period};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         play_ptr <= '0;
      end else if (!play) begin
         cnt <= span;
      end else if (cnt == CNT_W'(1)) begin
         cnt      <= span;
         play_ptr <= play_ptr + PTR_W'(1);
      end else begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !play |=> $stable(play_ptr));
   a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(play_ptr) |-> play_ptr == $past(play_ptr) + PTR_W'(1));
endmodule

// File: rtl/wt_wave_store.sv
module wt_wave_store #(
   parameter int DEPTH    = 32,
   parameter int SAMPLE_W = 5,
   localparam int PTR_W   = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                rewind,
   input  logic [SAMPLE_W-1:0] load_data,
   input  logic [PTR_W-1:0]    rd_ptr,
   output logic [PTR_W-1:0]    load_ptr,
   output logic [SAMPLE_W-1:0] rd_sample
);
   if (DEPTH != (1 << PTR_W)) begin : g_bad_depth
      $error("wt_wave_store: DEPTH must be a power of two");
   end

   logic [SAMPLE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_ptr <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (rewind) begin
         load_ptr <= '0;
      end else if (load) begin
         mem[load_ptr] <= load_data;
         load_ptr      <= load_ptr + PTR_W'(1);
      end
   end

   assign rd_sample = mem[rd_ptr];

   a_r5_load_steps: assert property (@(posedge clk) disable iff (!rst_n)
      load && !rewind |=> load_ptr == $past(load_ptr) + PTR_W'(1));
   a_r6_rewind_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rewind |=> load_ptr == '0);
endmodule

// File: rtl/wt_voice.sv
module wt_voice
   import wt_regs_pkg::*;
#(
   parameter int PERIOD_W  = 12,
   parameter int DEPTH     = 32,
   parameter int SAMPLE_W  = 5,
   parameter bit HAS_NOISE = 1'b0,
   localparam int PTR_W    = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel_wr,
   input  logic [3:0]          addr,
   input  logic [7:0]          data,
   output logic [PERIOD_W-1:0] period,
   output logic                play,
   output logic                direct,
   output logic [LEVEL_W-1:0]  level,
   output logic [7:0]          bal,
   output logic                noise_en,
   output logic [NOISE_W-1:0]  noise_rate,
   output logic [PTR_W-1:0]    load_ptr,
   output logic [PTR_W-1:0]    play_ptr,
   output logic [SAMPLE_W-1:0] sample
);
   localparam int HI_W = PERIOD_W - 8;

   logic wave_load, wave_rewind;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period <= '0;
         play   <= 1'b0;
         direct <= 1'b0;
         level  <= '0;
         bal    <= '0;
      end else if (sel_wr) begin
         case (addr)
            RA_PER_LO: period[7:0]          <= data;
            RA_PER_HI: period[PERIOD_W-1:8] <= data[HI_W-1:0];
            RA_CTRL: begin
               play   <= data[CTRL_PLAY_BIT];
               direct <= data[CTRL_DIR_BIT];
               level  <= data[LEVEL_W-1:0];
            end
            RA_VBAL:   bal <= data;
            default: ;
         endcase
      end
   end

   // noise fields exist only where the option is built
   if (HAS_NOISE) begin : g_noise
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            noise_en   <= 1'b0;
            noise_rate <= '0;
         end else if (sel_wr && addr == RA_NOISE) begin
            noise_en   <= data[7];
            noise_rate <= data[NOISE_W-1:0];
         end
      end
   end else begin : g_no_noise
      assign noise_en   = 1'b0;
      assign noise_rate = '0;
   end

   assign wave_load   = sel_wr && addr == RA_WAVE && !play;
   assign wave_rewind = sel_wr && addr == RA_CTRL &&
                        !data[CTRL_PLAY_BIT] && data[CTRL_DIR_BIT];

   wt_wave_store #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wave_load),
      .rewind    (wave_rewind),
      .load_data (data[SAMPLE_W-1:0]),
      .rd_ptr    (play_ptr),
      .load_ptr  (load_ptr),
      .rd_sample (sample)
   );

   wt_play_timer #(.PERIOD_W(PERIOD_W), .PTR_W(PTR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .play     (play),
      .period   (period),
      .play_ptr (play_ptr)
   );

   a_r5_frozen_when_playing: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr && addr == RA_WAVE && play |=> $stable(load_ptr));
   a_r4_ctrl_fields: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr && addr == RA_CTRL |=> play == $past(data[CTRL_PLAY_BIT]) &&
                                    level == $past(data[LEVEL_W-1:0]));
endmodule

// File: rtl/wt_sound_regs.sv
module wt_sound_regs
   import wt_regs_pkg::*;
#(
   parameter int NUM_V       = 6,
   parameter int DEPTH       = 32,
   parameter int SAMPLE_W    = 5,
   parameter int PERIOD_W    = 12,
   parameter int NOISE_FIRST = 4,
   localparam int PTR_W      = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [3:0]                wr_addr,
   input  logic [7:0]                wr_data,
   output logic [2:0]                bank_sel,
   output logic [7:0]                master_bal,
   output logic [7:0]                lfo_rate,
   output logic                      lfo_trig,
   output logic [1:0]                lfo_mode,
   output logic [NUM_V*PERIOD_W-1:0] v_period,
   output logic [NUM_V-1:0]          v_play,
   output logic [NUM_V-1:0]          v_direct,
   output logic [NUM_V*LEVEL_W-1:0]  v_level,
   output logic [NUM_V*8-1:0]        v_bal,
   output logic [NUM_V-1:0]          v_noise_en,
   output logic [NUM_V*NOISE_W-1:0]  v_noise_rate,
   output logic [NUM_V*PTR_W-1:0]    v_load_ptr,
   output logic [NUM_V*PTR_W-1:0]    v_play_ptr,
   output logic [NUM_V*SAMPLE_W-1:0] v_sample
);
   if (NUM_V < 1 || NUM_V > 8) begin : g_bad_voices
      $error("wt_sound_regs: NUM_V must be 1..8");
   end
   if (PERIOD_W < 9 || PERIOD_W > 16) begin : g_bad_period
      $error("wt_sound_regs: PERIOD_W must be 9..16");
   end
   if (SAMPLE_W < 1 || SAMPLE_W > 8) begin : g_bad_sample
      $error("wt_sound_regs: SAMPLE_W must be 1..8");
   end

   logic voice_reg;
   assign voice_reg = wr_en && wr_addr >= RA_PER_LO && wr_addr <= RA_NOISE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_sel   <= '0;
         master_bal <= '0;
         lfo_rate   <= '0;
         lfo_trig   <= 1'b0;
         lfo_mode   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            RA_BANK:     bank_sel   <= wr_data[2:0];
            RA_MBAL:     master_bal <= wr_data;
            RA_LFO_RATE: lfo_rate   <= wr_data;
            RA_LFO_CTRL: begin
               lfo_trig <= wr_data[7];
               lfo_mode <= wr_data[1:0];
            end
            default: ;
         endcase
      end
   end

   for (genvar v = 0; v < NUM_V; v++) begin : g_voice
      logic sel_wr;
      assign sel_wr = voice_reg && bank_sel == 3'(v);

      wt_voice #(
         .PERIOD_W  (PERIOD_W),
         .DEPTH     (DEPTH),
         .SAMPLE_W  (SAMPLE_W),
         .HAS_NOISE (v >= NOISE_FIRST)
      ) u_voice (
         .clk        (clk),
         .rst_n      (rst_n),
         .sel_wr     (sel_wr),
         .addr       (wr_addr),
         .data       (wr_data),
         .period     (v_period[v*PERIOD_W +: PERIOD_W]),
         .play       (v_play[v]),
         .direct     (v_direct[v]),
         .level      (v_level[v*LEVEL_W +: LEVEL_W]),
         .bal        (v_bal[v*8 +: 8]),
         .noise_en   (v_noise_en[v]),
         .noise_rate (v_noise_rate[v*NOISE_W +: NOISE_W]),
         .load_ptr   (v_load_ptr[v*PTR_W +: PTR_W]),
         .play_ptr   (v_play_ptr[v*PTR_W +: PTR_W]),
         .sample     (v_sample[v*SAMPLE_W +: SAMPLE_W])
      );
   end

   a_r1_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == RA_BANK |=> bank_sel == $past(wr_data[2:0]));
   a_r11_high_bank_inert: assert property (@(posedge clk) disable iff (!rst_n)
      voice_reg && bank_sel >= 3'(NUM_V) |=>
         $stable(v_period) && $stable(v_play) && $stable(v_level) &&
         $stable(v_bal) && $stable(v_load_ptr) && $stable(v_noise_en));
   a_r8_lfo_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == RA_LFO_CTRL |=>
         lfo_mode == $past(wr_data[1:0]) && lfo_trig == $past(wr_data[7]));
endmodule

// File: tb/wt_sound_regs_tb.sv
module wt_sound_regs_tb_top;
   localparam int NV = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;

   logic [2:0]     bank_sel;
   logic [7:0]     master_bal, lfo_rate;
   logic           lfo_trig;
   logic [1:0]     lfo_mode;
   logic [NV*12-1:0] v_period;
   logic [NV-1:0]  v_play, v_direct, v_noise_en;
   logic [NV*5-1:0] v_level, v_noise_rate, v_load_ptr, v_play_ptr, v_sample;
   logic [NV*8-1:0] v_bal;

   always #2 clk = ~clk;

   wt_sound_regs dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .bank_sel(bank_sel), .master_bal(master_bal), .lfo_rate(lfo_rate),
      .lfo_trig(lfo_trig), .lfo_mode(lfo_mode), .v_period(v_period),
      .v_play(v_play), .v_direct(v_direct), .v_level(v_level), .v_bal(v_bal),
      .v_noise_en(v_noise_en), .v_noise_rate(v_noise_rate),
      .v_load_ptr(v_load_ptr), .v_play_ptr(v_play_ptr), .v_sample(v_sample)
   );

   // behavioural reference model
   int m_sel, m_mbal, m_lrate, m_ltrig, m_lmode;
   int m_per[NV], m_play[NV], m_dir[NV], m_lvl[NV], m_bal[NV];
   int m_nen[NV], m_nrate[NV], m_lp[NV], m_pp[NV], m_cnt[NV];
   int m_wave[NV][32];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sel = 0; m_mbal = 0; m_lrate = 0; m_ltrig = 0; m_lmode = 0;
         for (int v = 0; v < NV; v++) begin
            m_per[v] = 0; m_play[v] = 0; m_dir[v] = 0; m_lvl[v] = 0; m_bal[v] = 0;
            m_nen[v] = 0; m_nrate[v] = 0; m_lp[v] = 0; m_pp[v] = 0; m_cnt[v] = 0;
            for (int e = 0; e < 32; e++) m_wave[v][e] = 0;
         end
      end else begin
         for (int v = 0; v < NV; v++) begin
            int span;
            span = (m_per[v] == 0) ? 4096 : m_per[v];
            if (m_play[v] == 0) m_cnt[v] = span;
            else if (m_cnt[v] == 1) begin
               m_cnt[v] = span;
               m_pp[v] = (m_pp[v] + 1) % 32;
            end else m_cnt[v] = m_cnt[v] - 1;
         end
         if (wr_en) begin
            int d;
            d = int'(wr_data);
            case (int'(wr_addr))
               0: m_sel = d & 7;
               1: m_mbal = d;
               8: m_lrate = d;
               9: begin m_ltrig = (d >> 7) & 1; m_lmode = d & 3; end
               default: if (wr_addr >= 2 && wr_addr <= 7 && m_sel < NV) begin
                  case (int'(wr_addr))
                     2: m_per[m_sel] = (m_per[m_sel] & 'hF00) | d;
                     3: m_per[m_sel] = (m_per[m_sel] & 'hFF) | ((d & 15) << 8);
                     4: begin
                        m_play[m_sel] = (d >> 7) & 1;
                        m_dir[m_sel]  = (d >> 6) & 1;
                        m_lvl[m_sel]  = d & 31;
                        if (m_play[m_sel] == 0 && m_dir[m_sel] == 1) m_lp[m_sel] = 0;
                     end
                     5: m_bal[m_sel] = d;
                     6: if (m_play[m_sel] == 0) begin
                        m_wave[m_sel][m_lp[m_sel]] = d & 31;
                        m_lp[m_sel] = (m_lp[m_sel] + 1) % 32;
                     end
                     7: if (m_sel >= 4) begin
                        m_nen[m_sel] = (d >> 7) & 1;
                        m_nrate[m_sel] = d & 31;
                     end
                     default: ;
                  endcase
               end
            endcase
         end
      end
   end

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 bank", 32'(bank_sel), m_sel);
         chk("R2 master balance", 32'(master_bal), m_mbal);
         chk("R8 lfo rate", 32'(lfo_rate), m_lrate);
         chk("R8 lfo ctrl", {29'd0, lfo_trig, lfo_mode}, (m_ltrig << 2) | m_lmode);
         for (int v = 0; v < NV; v++) begin
            chk("R3 period", 32'(v_period[v*12 +: 12]), m_per[v]);
            chk("R4 ctrl", {25'd0, v_play[v], v_direct[v], v_level[v*5 +: 5]},
                (m_play[v] << 6) | (m_dir[v] << 5) | m_lvl[v]);
            chk("R2 voice balance", 32'(v_bal[v*8 +: 8]), m_bal[v]);
            chk("R7 noise", {26'd0, v_noise_en[v], v_noise_rate[v*5 +: 5]},
                (m_nen[v] << 5) | m_nrate[v]);
            chk("R5 R6 load ptr", 32'(v_load_ptr[v*5 +: 5]), m_lp[v]);
            chk("R9 play ptr", 32'(v_play_ptr[v*5 +: 5]), m_pp[v]);
            chk("R10 sample", 32'(v_sample[v*5 +: 5]), m_wave[v][m_pp[v]]);
         end
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R1, R9)
      chk("R1 reset bank", 32'(bank_sel), 0);
      chk("R9 reset play flags", 32'(v_play), 0);
      // shared registers (R2, R8), unused addresses (R1)
      wr(1, 'hA5);
      wr(8, 'h3C);
      wr(9, 'h83);
      wr(9, 'h7E);
      wr(12, 'hFF);
      wr(15, 'h01);
      // voice 0: rewind, fill table with wrap-around (R5, R6)
      wr(0, 0);
      wr(4, 'h40);
      for (int i = 0; i < 35; i++) wr(6, (i * 7 + 3) % 32);
      wr(4, 'h1F);           // load mode, pointer kept (R6)
      wr(6, 9);
      wr(4, 'h40);           // rewind (R6)
      wr(2, 3);
      wr(3, 'hF0);           // upper nibble discarded (R3)
      wr(5, 'h5A);
      wr(4, 'h9F);           // play, period 3 (R4, R9)
      idle(40);
      wr(6, 17);             // ignored while playing (R5)
      idle(10);
      // period rewrite at every phase, hits the reload edge (R10)
      for (int off = 0; off < 4; off++) begin
         idle(off);
         wr(2, (off % 2 == 0) ? 2 : 3);
         idle(9);
      end
      // noise only on upper voices (R7)
      wr(0, 4); wr(7, 'h95);
      wr(0, 2); wr(7, 'h95);
      wr(0, 5); wr(7, 'h8A);
      // voice 5: zero period means 4096 (R9)
      wr(2, 0); wr(3, 0);
      wr(4, 'h40);
      for (int i = 0; i < 32; i++) wr(6, 31 - i);
      wr(4, 'h8C);
      idle(8300);
      // high banks are inert (R11)
      wr(0, 6);
      wr(2, 'h11); wr(4, 'h9F); wr(6, 5); wr(5, 'h33); wr(7, 'h9F);
      wr(0, 7);
      wr(3, 'h0A); wr(4, 'h40); wr(6, 6);
      wr(0, 1);
      wr(5, 'hC3);
      // stop voice 0, load mode continues from its pointer (R5, R9)
      wr(0, 0);
      wr(4, 'h1F);
      idle(6);
      wr(6, 21);
      wr(6, 22);
      idle(5);
      finish_run();
   end
endmodule